// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block drives a single-master I2C bus one byte per command. A host hands it a command on a valid/ready handshake. The command carries three qualifiers: whether to open with a START condition, whether to close with a STOP condition, and whether a read byte should be answered with NACK. The command also carries the byte to send.

The engine clocks out the eight data bits MSB first, runs the ninth acknowledge clock, and then either parks the bus with SCL held low and waits for the next command, or issues a STOP. The host must re-arm the engine for every byte, so STOP rides on the last byte of a transfer. The bus direction comes from the last address byte sent after a START: if bit 0 of that byte is 1, later bytes without START are reads.

SCL runs at one of two rates. Each half period of SCL is a count of system clocks, set by one parameter for standard mode and another for fast mode. Both lines are open drain and appear as pull-low enables with sampled inputs. Results come out as one-cycle event pulses and as level flags. The event pulses are byte done, received byte valid, bus error on a missing ACK, arbitration lost, and STOP finished. The level flags are the last ACK level, unit busy and bus busy. Register decoding and interrupt masking belong to the surrounding logic.

Top module: `i2c_byte_engine`

## Requirements
- R1: A command is accepted only on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low whenever `unit_en` or `sclk_en` is low. In that case `scl_oe` stays 0, and a waiting command leaves every output unchanged.
- R2: A command with `cmd_start`=1 first spends three half periods on START. In the first, SCL keeps its previous drive and SDA is released. In the second, both lines are released. In the third, `sda_oe`=1 and SCL stays released. `unit_busy` reads 1 from the first cycle after acceptance.
- R3: Every byte is nine SCL periods. Each bit is a half period with `scl_oe`=1 followed by a half period with `scl_oe`=0. Data goes out MSB first, with `sda_oe`=1 for a 0 bit and `sda_oe`=0 for a 1 bit. SDA does not change within the released-SCL half of a bit.
- R4: A half period lasts `STD_HALF` clocks when `fast_mode` is 0 at acceptance, and `FAST_HALF` clocks when it is 1. Line outputs change in the first cycle after the accepting edge.
- R5: A START byte with bit 0 = 1 makes the following non-START bytes reads. During a read, SDA is released for the eight data bits. SDA is sampled at the last clock of each released-SCL half. The byte appears on `rx_data` with a one-cycle `rx_valid`. In the ninth bit the engine sets `sda_oe` to the inverse of `cmd_nak`, so `cmd_nak`=0 sends ACK and `cmd_nak`=1 sends NACK.
- R6: With `cmd_stop`=1, the ninth bit is followed by three half periods. The first has SCL low and SDA low. The second has SCL released and SDA low. The third has both released. In the cycle after that, `mstop` pulses for one cycle, `unit_busy` reads 0 and `cmd_ready` reads 1.
- R7: On a write byte, the SDA level sampled in the ninth bit is stored in `ack_nak` (1 means NACK). When that level is 1, `bus_err` pulses together with `byte_done`.
- R8: If SDA samples low at the end of a released-SCL half of a write data bit that the engine released, the engine stops at once. In the next cycle `arb_lost` pulses, both line enables are 0, `unit_busy` is 0, and no STOP follows.
- R9: Without STOP, `byte_done` pulses for one cycle in the cycle after the ninth released-SCL half ends. From that cycle the engine holds `scl_oe`=1 and `sda_oe`=0, with `cmd_ready`=1.
- R10: `bus_busy` is set by any START seen on the sampled lines (SDA falling while SCL high). It is cleared by any STOP seen (SDA rising while SCL high).
- R11: Dropping `unit_en` or `sclk_en` while the bus is parked releases both lines and clears `unit_busy` in the next cycle.
- R12: `cmd_ready` stays low from acceptance until the byte, and any STOP attached to it, has finished. After reset `cmd_ready` is 1 with both enables set, every line enable and flag is 0, and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Unit enable |
| sclk_en | input | 1 | Bus clock output enable |
| fast_mode | input | 1 | 1 selects the fast half period, 0 the standard one |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_start | input | 1 | Open with a START condition |
| cmd_stop | input | 1 | Close with a STOP condition |
| cmd_nak | input | 1 | Read byte answered with NACK (1) or ACK (0) |
| cmd_data | input | DATA_W | Byte to send (address byte: target address in 7:1, read flag in 0) |
| rx_valid | output | 1 | One-cycle pulse, received byte on rx_data |
| rx_data | output | DATA_W | Last byte read |
| byte_done | output | 1 | One-cycle pulse at the end of a byte's ninth bit |
| ack_nak | output | 1 | Level of the last write byte's ninth bit (1 = NACK) |
| bus_err | output | 1 | One-cycle pulse, write byte not acknowledged |
| arb_lost | output | 1 | One-cycle pulse, arbitration lost |
| mstop | output | 1 | One-cycle pulse, STOP finished |
| unit_busy | output | 1 | Engine owns the bus (START to STOP) |
| bus_busy | output | 1 | A START has been seen on the bus and no STOP since |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |

## Verification
Every line change is due in the first cycle after the edge that accepts the command or closes a half period, and each half period spans exactly the selected count. The event pulses and `unit_busy` changes land in the first cycle of the phase that follows the closing half. The bench builds, for each command, a per-cycle queue of expected line enables, handshake and event values, plus the target's pull on SDA. It pops one entry at every falling clock edge, so the comparison is aligned to that latency with no slack. `bus_busy`, `ack_nak` and `rx_data` are checked only once the queue has drained, because the bus monitor trails the lines by one register.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  // Engine phases: parked states, START halves, bit halves, STOP halves.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SA,
    ST_SB,
    ST_SC,
    ST_BL,
    ST_BH,
    ST_P0,
    ST_P1,
    ST_P2
  } eng_st_e;

  function automatic logic is_parked(eng_st_e s);
    return (s == ST_IDLE) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [CW-1:0] half_len,
  output logic          tick
);

  logic [CW-1:0] cnt;

  assign tick = !hold && (cnt == half_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (hold || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (cnt < half_len)); // R4

endmodule

// File: rtl/i2c_shift_reg.sv
module i2c_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  output logic [W-1:0] q,
  output logic         msb
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], in_bit};
  end

  assign msb = q[W-1];

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic bus_busy
);

  logic scl_d, sda_d;
  logic start_ev, stop_ev;

  // Conditions only count while SCL was and still is high.
  assign start_ev = scl_in && scl_d && sda_d && !sda_in;
  assign stop_ev  = scl_in && scl_d && !sda_d && sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
      if (start_ev)     bus_busy <= 1'b1;
      else if (stop_ev) bus_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int STD_HALF  = 1000,
  parameter int FAST_HALF = 250,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic              sclk_en,
  input  logic              fast_mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_nak,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              byte_done,
  output logic              ack_nak,
  output logic              bus_err,
  output logic              arb_lost,
  output logic              mstop,
  output logic              unit_busy,
  output logic              bus_busy,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              scl_in,
  input  logic              sda_in
);
  import i2c_eng_pkg::*;

  localparam int MAXH = (STD_HALF > FAST_HALF) ? STD_HALF : FAST_HALF;
  localparam int CW   = $clog2(MAXH + 1);
  localparam int BCW  = $clog2(DATA_W + 1);
  localparam logic [BCW-1:0] ACK_IDX = BCW'(DATA_W);

  eng_st_e           st;
  logic [BCW-1:0]    bit_cnt;
  logic [CW-1:0]     half_q;
  logic              start_q, stop_q, nak_q, rd_cur, rd_mode, from_hold;
  logic              busy_q, ack_q;
  logic              done_q, berr_q, arb_q, mstop_q, rxv_q;
  logic [DATA_W-1:0] rx_q;

  logic              en, accept, tick, last_bit;
  logic              sh_load, sh_shift, sh_msb;
  logic [DATA_W-1:0] sh_q;
  logic              data_drive, ack_drive, bit_drive;

  assign en        = unit_en && sclk_en;
  assign cmd_ready = en && is_parked(st);
  assign accept    = cmd_valid && cmd_ready;
  assign last_bit  = (bit_cnt == ACK_IDX);

  i2c_half_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (is_parked(st)),
    .half_len (half_q),
    .tick     (tick)
  );

  assign sh_load  = accept;
  assign sh_shift = (st == ST_BH) && tick && !last_bit;

  i2c_shift_reg #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (cmd_data),
    .shift    (sh_shift),
    .in_bit   (sda_in),
    .q        (sh_q),
    .msb      (sh_msb)
  );

  i2c_bus_watch u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .bus_busy (bus_busy)
  );

  // Phase sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      half_q    <= CW'(STD_HALF);
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
      nak_q     <= 1'b0;
      rd_cur    <= 1'b0;
      rd_mode   <= 1'b0;
      from_hold <= 1'b0;
      busy_q    <= 1'b0;
      ack_q     <= 1'b0;
      rx_q      <= '0;
      done_q    <= 1'b0;
      berr_q    <= 1'b0;
      arb_q     <= 1'b0;
      mstop_q   <= 1'b0;
      rxv_q     <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      berr_q  <= 1'b0;
      arb_q   <= 1'b0;
      mstop_q <= 1'b0;
      rxv_q   <= 1'b0;
      if (!en) begin
        st     <= ST_IDLE;
        busy_q <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE, ST_HOLD: begin
            if (cmd_valid) begin
              start_q   <= cmd_start;
              stop_q    <= cmd_stop;
              nak_q     <= cmd_nak;
              rd_cur    <= !cmd_start && rd_mode;
              from_hold <= (st == ST_HOLD);
              half_q    <= fast_mode ? CW'(FAST_HALF) : CW'(STD_HALF);
              bit_cnt   <= '0;
              if (cmd_start) begin
                busy_q <= 1'b1;
                st     <= ST_SA;
              end else begin
                st     <= ST_BL;
              end
            end
          end
          ST_SA: if (tick) st <= ST_SB;
          ST_SB: if (tick) st <= ST_SC;
          ST_SC: if (tick) st <= ST_BL;
          ST_BL: if (tick) st <= ST_BH;
          ST_BH: begin
            if (tick) begin
              if (!last_bit) begin
                if (!rd_cur && sh_msb && !sda_in) begin
                  st     <= ST_IDLE;
                  arb_q  <= 1'b1;
                  busy_q <= 1'b0;
                end else begin
                  bit_cnt <= bit_cnt + 1'b1;
                  st      <= ST_BL;
                end
              end else begin
                done_q <= 1'b1;
                if (rd_cur) begin
                  rx_q  <= sh_q;
                  rxv_q <= 1'b1;
                end else begin
                  ack_q  <= sda_in;
                  berr_q <= sda_in;
                end
                if (start_q) rd_mode <= sh_q[0];
                st <= stop_q ? ST_P0 : ST_HOLD;
              end
            end
          end
          ST_P0: if (tick) st <= ST_P1;
          ST_P1: if (tick) st <= ST_P2;
          ST_P2: begin
            if (tick) begin
              st      <= ST_IDLE;
              mstop_q <= 1'b1;
              busy_q  <= 1'b0;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // Line drive per phase
  assign data_drive = rd_cur ? 1'b0 : !sh_msb;
  assign ack_drive  = rd_cur ? !nak_q : 1'b0;
  assign bit_drive  = last_bit ? ack_drive : data_drive;

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    unique case (st)
      ST_HOLD: scl_oe = 1'b1;
      ST_SA:   scl_oe = from_hold;
      ST_SC:   sda_oe = 1'b1;
      ST_BL: begin
        scl_oe = 1'b1;
        sda_oe = bit_drive;
      end
      ST_BH:   sda_oe = bit_drive;
      ST_P0: begin
        scl_oe = 1'b1;
        sda_oe = 1'b1;
      end
      ST_P1:   sda_oe = 1'b1;
      default: ;
    endcase
  end

  assign rx_valid  = rxv_q;
  assign rx_data   = rx_q;
  assign byte_done = done_q;
  assign ack_nak   = ack_q;
  assign bus_err   = berr_q;
  assign arb_lost  = arb_q;
  assign mstop     = mstop_q;
  assign unit_busy = busy_q;

  AST_SCL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> $past(unit_en && sclk_en)); // R1

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BH && $past(st) == ST_BH) |-> $stable(sda_oe)); // R3

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    mstop |-> (!unit_busy && !scl_oe && !sda_oe)); // R6

  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (!unit_busy && !scl_oe && !sda_oe)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done); // R9

  AST_START_MARKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SC && $past(st) == ST_SB) |=> bus_busy); // R10

endmodule

// File: tb/sim_i2c_byte_engine.sv
`timescale 1ns/1ps
module sim_i2c_byte_engine;

  localparam int STD_H  = 6;
  localparam int FAST_H = 2;
  localparam int W      = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic unit_en = 1'b1, sclk_en = 1'b1, fast_mode = 1'b0;
  logic cmd_valid = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0, cmd_nak = 1'b0;
  logic [W-1:0] cmd_data = '0;
  logic cmd_ready, rx_valid, byte_done, ack_nak, bus_err, arb_lost, mstop;
  logic unit_busy, bus_busy, scl_oe, sda_oe, scl_in, sda_in;
  logic [W-1:0] rx_data;
  logic tgt_low = 1'b0;

  assign scl_in = !scl_oe;
  assign sda_in = !(sda_oe || tgt_low);

  i2c_byte_engine #(.STD_HALF(STD_H), .FAST_HALF(FAST_H), .DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .sclk_en(sclk_en),
    .fast_mode(fast_mode), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_nak(cmd_nak),
    .cmd_data(cmd_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .byte_done(byte_done), .ack_nak(ack_nak), .bus_err(bus_err),
    .arb_lost(arb_lost), .mstop(mstop), .unit_busy(unit_busy),
    .bus_busy(bus_busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_in(scl_in), .sda_in(sda_in)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  string cur_req = "R12";

  // Reference model state
  logic [8:0] exp_q[$];
  bit         tgt_q[$];
  bit rest_scl = 0, en_m = 1, busy_m = 0, rd_m = 0;
  logic [4:0] pend = '0;   // {done, berr, arb, mstop, rxv}
  int hlen = STD_H;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [8:0] e;
    bit t;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tgt_q.pop_front();
    end else begin
      e = {rest_scl, 1'b0, en_m, 5'b0, busy_m};
      t = 1'b0;
    end
    check(cur_req, "scl/sda/ready/done/berr/arb/mstop/rxv/busy",
          {23'd0, scl_oe, sda_oe, cmd_ready, byte_done, bus_err, arb_lost, mstop, rx_valid, unit_busy},
          {23'd0, e});
    tgt_low = t;
  endtask

  task automatic push_one(bit s, bit d, bit t);
    exp_q.push_back({s, d, 1'b0, pend, busy_m});
    tgt_q.push_back(t);
    pend = '0;
  endtask

  task automatic push_half(bit s, bit d, bit t);
    for (int k = 0; k < hlen; k++) push_one(s, d, t);
  endtask

  task automatic push_rest();
    exp_q.push_back({rest_scl, 1'b0, en_m, pend, busy_m});
    tgt_q.push_back(1'b0);
    pend = '0;
  endtask

  // One command; arb_bit selects a data bit the target pulls low (-1: none).
  task automatic do_byte(bit st, bit sp, bit nak, logic [7:0] d, bit ack,
                         logic [7:0] rdat, int arb_bit, string req);
    bit rd, lost, drv, tl;
    rd = !st && rd_m;
    lost = 0;
    hlen = fast_mode ? FAST_H : STD_H;
    cur_req = req;
    cmd_valid = 1; cmd_start = st; cmd_stop = sp; cmd_nak = nak; cmd_data = d;
    if (st) begin
      busy_m = 1;
      push_half(rest_scl, 0, 0);
      push_half(0, 0, 0);
      push_half(0, 1, 0);
    end
    for (int i = 7; i >= 0; i--) begin
      drv = rd ? 1'b0 : !d[i];
      tl  = rd ? !rdat[i] : (i == arb_bit);
      push_half(1, drv, tl);
      push_half(0, drv, tl);
      if (!rd && d[i] && tl) begin
        lost = 1;
        break;
      end
    end
    if (lost) begin
      busy_m = 0;
      rest_scl = 0;
      pend = 5'b00100;
      push_rest();
    end else begin
      push_half(1, rd ? !nak : 1'b0, rd ? 1'b0 : ack);
      push_half(0, rd ? !nak : 1'b0, rd ? 1'b0 : ack);
      pend = {1'b1, !rd && !ack, 1'b0, 1'b0, rd};
      if (st) rd_m = d[0];
      if (sp) begin
        push_half(1, 1, 0);
        push_half(0, 1, 0);
        push_half(0, 0, 0);
        busy_m = 0;
        rest_scl = 0;
        pend = 5'b00010;
        push_rest();
      end else begin
        rest_scl = 1;
        push_rest();
      end
    end
    step();
    cmd_valid = 0;
    while (exp_q.size() > 0) step();
    if (rd) check(req, "rx_data", {24'd0, rx_data}, {24'd0, rdat});
    else if (!lost) check(req, "ack_nak", {31'd0, ack_nak}, {31'd0, !ack});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // Reset state (R12)
    cur_req = "R12";
    repeat (3) step();
    check("R12", "bus_busy", {31'd0, bus_busy}, 32'd0);
    check("R12", "ack_nak", {31'd0, ack_nak}, 32'd0);
    check("R12", "rx_data", {24'd0, rx_data}, 32'd0);

    // R1: commands ignored while an enable is low
    cur_req = "R1";
    sclk_en = 0; en_m = 0;
    cmd_valid = 1; cmd_start = 1; cmd_data = 8'hA0;
    repeat (8) step();
    unit_en = 0; sclk_en = 1;
    repeat (8) step();
    cmd_valid = 0; unit_en = 1; en_m = 1;
    step();
    check("R1", "bus_busy after ignored command", {31'd0, bus_busy}, 32'd0);

    // Standard-rate write with ACKs, then NACK with STOP
    do_byte(1, 0, 0, 8'hA0, 1, 8'h00, -1, "R2");
    check("R10", "bus_busy after START", {31'd0, bus_busy}, 32'd1);
    do_byte(0, 0, 0, 8'h3C, 1, 8'h00, -1, "R3,R12");
    do_byte(0, 1, 0, 8'h81, 0, 8'h00, -1, "R6,R7");
    check("R10", "bus_busy after STOP", {31'd0, bus_busy}, 32'd0);

    // Fast-rate read
    fast_mode = 1;
    do_byte(1, 0, 0, 8'hA1, 1, 8'h00, -1, "R4");
    do_byte(0, 0, 0, 8'h00, 1, 8'h5A, -1, "R5");
    do_byte(0, 1, 1, 8'h00, 1, 8'hC3, -1, "R5,R6");
    fast_mode = 0;

    // Repeated START switches a write into a read
    do_byte(1, 0, 0, 8'hA2, 1, 8'h00, -1, "R2");
    do_byte(1, 0, 0, 8'hA3, 1, 8'h00, -1, "R2");
    do_byte(0, 1, 1, 8'h00, 1, 8'h96, -1, "R5");

    // Arbitration loss on the second address bit
    do_byte(1, 0, 0, 8'hE4, 1, 8'h00, 6, "R8");
    cur_req = "R8";
    repeat (3) step();
    check("R10", "bus_busy after lines freed", {31'd0, bus_busy}, 32'd0);
    do_byte(1, 1, 0, 8'h42, 1, 8'h00, -1, "R6");

    // Parked bus, then an enable drops
    do_byte(1, 0, 0, 8'hA0, 1, 8'h00, -1, "R9");
    cur_req = "R11";
    sclk_en = 0; en_m = 0; rest_scl = 0; busy_m = 0;
    repeat (3) step();
    sclk_en = 1; en_m = 1;
    step();

    // Address NACK with STOP
    do_byte(1, 1, 0, 8'hB0, 0, 8'h00, -1, "R7");
    check("R10", "bus_busy end", {31'd0, bus_busy}, 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule